// File: doc/BRIEF.md
# USB Packet Byte Parser

This block sits behind a USB bit-level receiver. The receiver has already done the NRZI decoding and removed the stuffed bits. The parser takes the receiver's tagged events (packet start, one data bit, packet end, stuffing violation) and rebuilds bytes from them, least significant bit first. It accepts a packet only after a correct SYNC byte and a PID whose upper nibble is the complement of its lower nibble.

Each accepted packet is sorted by PID into one of three classes: handshake, token or data. Token packets are checked with a serial CRC5 engine and data packets with a serial CRC16 engine. At the end of every classified packet the parser reports a seven-bit status word for one cycle.

Data packets also go to a downstream receive FIFO as a marked byte stream:
- a start marker, which carries the PID;
- one stream entry for each byte after the PID, the two CRC bytes included;
- a stop marker, which carries the status word.

While the local side is answering with NAK, nothing is written to the FIFO.

Top module: `usb_pkt_parser`

## Requirements
- R1: After reset, `fifoValid` and `statValid` are low, and the parser waits for a start event.
- R2: Input events use `evtCode`: 0 = start, 1 = bit, 2 = stop, 3 = stuff error. Bits are assembled least significant bit first. The first byte after start must equal 0x80. Any other value drops the packet silently, with no FIFO write and no status.
- R3: The second byte is the PID. It is valid only when bits 7:4 equal the bitwise complement of bits 3:0. An invalid PID, or a valid PID whose bits 1:0 are 00, drops the packet silently.
- R4: PID bits 1:0 = 10 is a handshake. ACK (0xD2) sets status bit 5, NAK (0x5A) sets bit 4's neighbour bit 3, and STALL (0x1E) sets bit 4. At most one of bits 5:3 is ever set.
- R5: PID bits 1:0 = 01 is a token. Status bit 0 (CRC error) is set at stop when the CRC5 over the bits after the PID does not leave the residual 01100. Tokens write nothing to the FIFO.
- R6: PID bits 1:0 = 11 is a data packet. The FIFO receives:
  - code 0 (start) with the PID;
  - code 1 (stream) for each following byte;
  - code 2 (stop) with {0, status}.

  Status bit 6 equals PID bit 3. Status bit 0 flags a CRC16 residual other than 0x800D.
- R7: When a data byte completes while `fifoFull` is high, status bit 2 (overflow) is set and the byte is not written.
- R8: While `nakMode` is high, no FIFO entry of any kind is written, and the status is still reported.
- R9: A stuff-error event in a classified packet closes the packet at once. It sets status bit 1, skips the CRC verdict, writes the stop marker for data packets, and returns the parser to waiting.
- R10: `statValid` pulses for exactly one cycle per classified packet. For data packets it pulses in the same cycle as the stop marker. The status word starts cleared for every packet.
- R11: A start event in the middle of a packet discards that packet silently and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | Event present this cycle |
| evtCode | input | 2 | Event kind: 0 start, 1 bit, 2 stop, 3 stuff error |
| evtBit | input | 1 | Bit value for a bit event |
| fifoFull | input | 1 | Downstream FIFO cannot take a byte |
| nakMode | input | 1 | Local side is answering NAK; discard data |
| fifoValid | output | 1 | FIFO write strobe |
| fifoCtl | output | 2 | Entry kind: 0 start, 1 stream, 2 stop |
| fifoData | output | 8 | PID, data byte, or {0, status} |
| statValid | output | 1 | Status word valid, one cycle |
| statWord | output | 7 | Status: 0 CRC, 1 stuff, 2 overflow, 3 NAK, 4 STALL, 5 ACK, 6 data toggle |

## Verification
The bench builds the parser with its default parameters: 8-bit bytes, 0x80 as the SYNC value, and the standard CRC5 and CRC16 polynomials and residuals. The bench generates the CRC fields itself, as a transmitter would, so a correct residual check and a corrupted-CRC case can both be reached. These defaults are what allow real USB PIDs to be sent and checked: both data toggles, all three handshakes, a token, and the reserved class with PID bits 1:0 = 00.

// File: rtl/usb_pkt_parser_pkg.sv
package usb_pkt_parser_pkg;

  typedef enum logic [1:0] {
    EVT_START = 2'd0,
    EVT_BIT   = 2'd1,
    EVT_STOP  = 2'd2,
    EVT_STUFF = 2'd3
  } evt_e;

  typedef enum logic [1:0] {
    OUT_START  = 2'd0,
    OUT_STREAM = 2'd1,
    OUT_STOP   = 2'd2
  } outCtl_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_PID   = 3'd2,
    ST_HS    = 3'd3,
    ST_TOKEN = 3'd4,
    ST_DATA  = 3'd5
  } parseState_e;

  localparam int STAT_W    = 7;
  localparam int S_CRC     = 0;
  localparam int S_STUFF   = 1;
  localparam int S_OVF     = 2;
  localparam int S_NAK     = 3;
  localparam int S_STALL   = 4;
  localparam int S_ACK     = 5;
  localparam int S_TOGGLE  = 6;

  typedef struct packed {
    logic clear;
    logic crcEn;
  } dpStrobe_t;

endpackage

// File: rtl/usb_crc_serial.sv
module usb_crc_serial #(
  parameter int          WIDTH = 5,
  parameter logic [15:0] POLY  = 16'h0005,
  parameter logic [15:0] RESID = 16'h000C
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shiftEn,
  input  logic dataBit,
  output logic match
);
  logic [WIDTH-1:0] crcReg;
  logic             feedback;

  assign feedback = crcReg[WIDTH-1] ^ dataBit;
  assign match    = (crcReg == RESID[WIDTH-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crcReg <= '1;
    end else if (shiftEn) begin
      crcReg <= {crcReg[WIDTH-2:0], 1'b0} ^ (feedback ? POLY[WIDTH-1:0] : '0);
    end
  end
endmodule

// File: rtl/usb_pkt_datapath.sv
module usb_pkt_datapath
  import usb_pkt_parser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evtValid,
  input  logic [1:0]        evtCode,
  input  logic              evtBit,
  input  dpStrobe_t         strb,
  output logic [BYTE_W-1:0] byteVal,
  output logic              byteDone,
  output logic              crc5Ok,
  output logic              crc16Ok
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              isBit;

  assign isBit    = evtValid && (evtCode == EVT_BIT);
  assign byteVal  = {evtBit, shiftReg[BYTE_W-1:1]};
  assign byteDone = isBit && (bitCnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (isBit) begin
      bitCnt   <= byteDone ? '0 : bitCnt + 1'b1;
      shiftReg <= byteVal;
    end
  end

  usb_crc_serial #(.WIDTH(5), .POLY(16'h0005), .RESID(16'h000C)) crc5 (
    .clk(clk), .rst(rst), .clear(strb.clear),
    .shiftEn(isBit && strb.crcEn), .dataBit(evtBit), .match(crc5Ok)
  );

  usb_crc_serial #(.WIDTH(16), .POLY(16'h8005), .RESID(16'h800D)) crc16 (
    .clk(clk), .rst(rst), .clear(strb.clear),
    .shiftEn(isBit && strb.crcEn), .dataBit(evtBit), .match(crc16Ok)
  );
endmodule

// File: rtl/usb_pkt_control.sv
module usb_pkt_control
  import usb_pkt_parser_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  SYNC_PAT = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evtValid,
  input  logic [1:0]        evtCode,
  input  logic              fifoFull,
  input  logic              nakMode,
  input  logic [BYTE_W-1:0] byteVal,
  input  logic              byteDone,
  input  logic              crc5Ok,
  input  logic              crc16Ok,
  output dpStrobe_t         strb,
  output logic              fifoValid,
  output logic [1:0]        fifoCtl,
  output logic [BYTE_W-1:0] fifoData,
  output logic              statValid,
  output logic [STAT_W-1:0] statWord
);
  parseState_e       state;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] finalWord;
  logic              isStart, isStop, isStuff, classified, crcErr, endPkt;

  assign isStart    = evtValid && (evtCode == EVT_START);
  assign isStop     = evtValid && (evtCode == EVT_STOP);
  assign isStuff    = evtValid && (evtCode == EVT_STUFF);
  assign classified = (state == ST_HS) || (state == ST_TOKEN) || (state == ST_DATA);
  assign endPkt     = classified && (isStop || isStuff);
  assign strb.clear = isStart;
  assign strb.crcEn = (state == ST_TOKEN) || (state == ST_DATA);

  always_comb begin
    crcErr    = ((state == ST_TOKEN) && !crc5Ok) || ((state == ST_DATA) && !crc16Ok);
    finalWord = status;
    if (isStuff) finalWord[S_STUFF] = 1'b1;
    else if (crcErr) finalWord[S_CRC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      status    <= '0;
      fifoValid <= 1'b0;
      fifoCtl   <= '0;
      fifoData  <= '0;
      statValid <= 1'b0;
      statWord  <= '0;
    end else begin
      fifoValid <= 1'b0;
      statValid <= 1'b0;
      if (isStart) begin
        state  <= ST_SYNC;
        status <= '0;
      end else if (endPkt) begin
        state     <= ST_IDLE;
        statValid <= 1'b1;
        statWord  <= finalWord;
        if (state == ST_DATA && !nakMode) begin
          fifoValid <= 1'b1;
          fifoCtl   <= OUT_STOP;
          fifoData  <= BYTE_W'(finalWord);
        end
      end else begin
        unique case (state)
          ST_SYNC: begin
            if (isStop || isStuff) state <= ST_IDLE;
            else if (byteDone) state <= (byteVal == SYNC_PAT) ? ST_PID : ST_IDLE;
          end
          ST_PID: begin
            if (isStop || isStuff) state <= ST_IDLE;
            else if (byteDone) begin
              if (byteVal[7:4] != ~byteVal[3:0]) state <= ST_IDLE;
              else begin
                unique case (byteVal[1:0])
                  2'b01: state <= ST_TOKEN;
                  2'b10: begin
                    state <= ST_HS;
                    status[S_ACK]   <= (byteVal[3:2] == 2'b00);
                    status[S_NAK]   <= (byteVal[3:2] == 2'b10);
                    status[S_STALL] <= (byteVal[3:2] == 2'b11);
                  end
                  2'b11: begin
                    state <= ST_DATA;
                    status[S_TOGGLE] <= byteVal[3];
                    if (!nakMode) begin
                      fifoValid <= 1'b1;
                      fifoCtl   <= OUT_START;
                      fifoData  <= byteVal;
                    end
                  end
                  default: state <= ST_IDLE;
                endcase
              end
            end
          end
          ST_DATA: begin
            if (byteDone && !nakMode) begin
              if (fifoFull) status[S_OVF] <= 1'b1;
              else begin
                fifoValid <= 1'b1;
                fifoCtl   <= OUT_STREAM;
                fifoData  <= byteVal;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_pkt_parser.sv
module usb_pkt_parser
  import usb_pkt_parser_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [7:0] SYNC_PAT = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evtValid,
  input  logic [1:0]        evtCode,
  input  logic              evtBit,
  input  logic              fifoFull,
  input  logic              nakMode,
  output logic              fifoValid,
  output logic [1:0]        fifoCtl,
  output logic [BYTE_W-1:0] fifoData,
  output logic              statValid,
  output logic [6:0]        statWord
);
  dpStrobe_t         strb;
  logic [BYTE_W-1:0] byteVal;
  logic              byteDone, crc5Ok, crc16Ok;

  usb_pkt_datapath #(.BYTE_W(BYTE_W)) dp (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtCode(evtCode), .evtBit(evtBit),
    .strb(strb), .byteVal(byteVal), .byteDone(byteDone), .crc5Ok(crc5Ok), .crc16Ok(crc16Ok)
  );

  usb_pkt_control #(.BYTE_W(BYTE_W), .SYNC_PAT(SYNC_PAT)) ctl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtCode(evtCode),
    .fifoFull(fifoFull), .nakMode(nakMode), .byteVal(byteVal), .byteDone(byteDone),
    .crc5Ok(crc5Ok), .crc16Ok(crc16Ok), .strb(strb),
    .fifoValid(fifoValid), .fifoCtl(fifoCtl), .fifoData(fifoData),
    .statValid(statValid), .statWord(statWord)
  );
endmodule

// File: rtl/usb_pkt_parser_chk.sv
module usb_pkt_parser_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              evtValid,
  input logic              fifoFull,
  input logic              nakMode,
  input logic              fifoValid,
  input logic [1:0]        fifoCtl,
  input logic [BYTE_W-1:0] fifoData,
  input logic              statValid,
  input logic [6:0]        statWord
);
  p_hs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    statValid |-> $countones(statWord[5:3]) <= 1);

  p_stop_carries_status_r6: assert property (@(posedge clk) disable iff (rst)
    (fifoValid && fifoCtl == 2'd2) |-> (statValid && fifoData[6:0] == statWord));

  p_ctl_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    fifoValid |-> fifoCtl != 2'd3);

  p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    fifoFull |=> !(fifoValid && fifoCtl == 2'd1));

  p_nak_discards_r8: assert property (@(posedge clk) disable iff (rst)
    nakMode |=> !fifoValid);

  p_status_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    statValid |=> !statValid);

  p_status_follows_event_r10: assert property (@(posedge clk) disable iff (rst)
    statValid |-> $past(evtValid));
endmodule

bind usb_pkt_parser usb_pkt_parser_chk #(.BYTE_W(BYTE_W)) chk (
  .clk(clk), .rst(rst), .evtValid(evtValid), .fifoFull(fifoFull), .nakMode(nakMode),
  .fifoValid(fifoValid), .fifoCtl(fifoCtl), .fifoData(fifoData),
  .statValid(statValid), .statWord(statWord)
);

// File: tb/tb_usb_pkt_parser.sv
`timescale 1ns/1ps
module tb_usb_pkt_parser;
  logic clk = 0, rst = 1;
  logic evtValid = 0, evtBit = 0, fifoFull = 0, nakMode = 0;
  logic [1:0] evtCode = 0;
  logic fifoValid, statValid;
  logic [1:0] fifoCtl;
  logic [7:0] fifoData;
  logic [6:0] statWord;

  always #2.5 clk = ~clk;

  usb_pkt_parser dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtCode(evtCode), .evtBit(evtBit),
    .fifoFull(fifoFull), .nakMode(nakMode), .fifoValid(fifoValid), .fifoCtl(fifoCtl),
    .fifoData(fifoData), .statValid(statValid), .statWord(statWord)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int nFifo = 0, nStat = 0;
  logic [1:0] logCtl [0:63];
  logic [7:0] logData [0:63];
  logic [6:0] logStat [0:15];
  logic bitBuf [0:255];
  int nBits = 0;

  always @(negedge clk) if (!rst) begin
    if (fifoValid && nFifo < 64) begin logCtl[nFifo] = fifoCtl; logData[nFifo] = fifoData; nFifo++; end
    if (statValid && nStat < 16) begin logStat[nStat] = statWord; nStat++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendEvt(logic [1:0] code, logic b);
    evtValid = 1; evtCode = code; evtBit = b;
    @(negedge clk);
    evtValid = 0;
  endtask

  task automatic sendByte(logic [7:0] v);
    for (int i = 0; i < 8; i++) sendEvt(2'd1, v[i]);
  endtask

  task automatic pushBits(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin bitBuf[nBits] = v[i]; nBits++; end
  endtask

  task automatic pushCrc(int w);
    logic [15:0] c, poly;
    logic fb;
    c = 16'hFFFF; poly = (w == 5) ? 16'h0005 : 16'h8005;
    for (int i = 0; i < nBits; i++) begin
      fb = c[w-1] ^ bitBuf[i];
      c = (c << 1) ^ (fb ? poly : 16'h0);
    end
    for (int i = w - 1; i >= 0; i--) begin bitBuf[nBits] = ~c[i]; nBits++; end
  endtask

  function automatic logic [7:0] bufByte(int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = bitBuf[8*k + i];
    return v;
  endfunction

  task automatic sendPkt(logic [7:0] syncB, logic [7:0] pid, bit withStop);
    nFifo = 0; nStat = 0;
    sendEvt(2'd0, 0);
    sendByte(syncB);
    sendByte(pid);
    for (int i = 0; i < nBits; i++) sendEvt(2'd1, bitBuf[i]);
    if (withStop) sendEvt(2'd2, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chkEq("R1 fifoValid after reset", fifoValid, 0);
    chkEq("R1 statValid after reset", statValid, 0);
  endtask

  task automatic t_badSync;
    nBits = 0;
    sendPkt(8'h81, 8'hD2, 1);
    chkEq("R2 bad sync status count", nStat, 0);
    chkEq("R2 bad sync fifo count", nFifo, 0);
  endtask

  task automatic t_badPid;
    nBits = 0;
    sendPkt(8'h80, 8'hD3, 1);
    chkEq("R3 uncomplemented pid status count", nStat, 0);
    sendPkt(8'h80, 8'h3C, 1);
    chkEq("R3 reserved class status count", nStat, 0);
  endtask

  task automatic t_handshake;
    logic [7:0] pids [3] = '{8'hD2, 8'h5A, 8'h1E};
    int exps [3] = '{32'h20, 32'h08, 32'h10};
    nBits = 0;
    for (int k = 0; k < 3; k++) begin
      sendPkt(8'h80, pids[k], 1);
      chkEq("R4 handshake status count", nStat, 1);
      chkEq("R4 R10 handshake status", logStat[0], exps[k]);
      chkEq("R4 handshake fifo count", nFifo, 0);
    end
  endtask

  task automatic t_token;
    nBits = 0; pushBits(16'h15, 7); pushBits(16'h3, 4); pushCrc(5);
    sendPkt(8'h80, 8'h69, 1);
    chkEq("R5 good token status", logStat[0], 0);
    chkEq("R5 token fifo count", nFifo, 0);
    bitBuf[nBits-1] = ~bitBuf[nBits-1];
    sendPkt(8'h80, 8'h69, 1);
    chkEq("R5 bad token crc status", logStat[0], 1);
  endtask

  task automatic t_data;
    nBits = 0; pushBits(16'h11, 8); pushBits(16'hA5, 8); pushBits(16'hFF, 8); pushCrc(16);
    sendPkt(8'h80, 8'h4B, 1);
    chkEq("R6 data fifo count", nFifo, 7);
    chkEq("R6 start code", logCtl[0], 0);
    chkEq("R6 start pid", logData[0], 8'h4B);
    for (int k = 0; k < 5; k++) begin
      chkEq("R6 stream code", logCtl[k+1], 1);
      chkEq("R6 stream byte", logData[k+1], bufByte(k));
    end
    chkEq("R6 stop code", logCtl[6], 2);
    chkEq("R6 stop carries status", logData[6], 8'h40);
    chkEq("R6 R10 data1 status", logStat[0], 7'h40);
    bitBuf[3] = ~bitBuf[3];
    sendPkt(8'h80, 8'hC3, 1);
    chkEq("R6 data0 bad crc status", logStat[0], 7'h01);
    chkEq("R6 data0 bad crc stop byte", logData[6], 8'h01);
  endtask

  task automatic t_overflow;
    nBits = 0; pushBits(16'h5E, 8); pushBits(16'h01, 8); pushCrc(16);
    fifoFull = 1;
    sendPkt(8'h80, 8'hC3, 1);
    fifoFull = 0;
    chkEq("R7 overflow fifo count", nFifo, 2);
    chkEq("R7 overflow status", logStat[0], 7'h04);
  endtask

  task automatic t_nak;
    nBits = 0; pushBits(16'h77, 8); pushCrc(16);
    nakMode = 1;
    sendPkt(8'h80, 8'hC3, 1);
    nakMode = 0;
    chkEq("R8 nak fifo count", nFifo, 0);
    chkEq("R8 nak status count", nStat, 1);
    chkEq("R8 nak status word", logStat[0], 0);
  endtask

  task automatic t_stuff;
    nBits = 0; pushBits(16'h3C, 8);
    sendPkt(8'h80, 8'hC3, 0);
    sendEvt(2'd3, 0);
    sendEvt(2'd2, 0);
    repeat (3) @(negedge clk);
    chkEq("R9 stuff fifo count", nFifo, 3);
    chkEq("R9 stuff stream byte", logData[1], 8'h3C);
    chkEq("R9 stuff stop byte", logData[2], 8'h02);
    chkEq("R9 R10 stuff status count", nStat, 1);
    chkEq("R9 stuff status", logStat[0], 7'h02);
  endtask

  task automatic t_restart;
    nFifo = 0; nStat = 0;
    sendEvt(2'd0, 0); sendByte(8'h80); sendByte(8'h5A);
    nBits = 0;
    sendEvt(2'd0, 0); sendByte(8'h80); sendByte(8'hD2); sendEvt(2'd2, 0);
    repeat (3) @(negedge clk);
    chkEq("R11 restart status count", nStat, 1);
    chkEq("R11 restart status", logStat[0], 7'h20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_badSync();
    t_badPid();
    t_handshake();
    t_token();
    t_data();
    t_overflow();
    t_nak();
    t_stuff();
    t_restart();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule